// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This block takes two binary32 operands and does one of two things with them. It can pick the smaller or the larger operand (min/max group), or it can test an ordering relation and return a single integer bit (compare group). It sits next to a floating-point register file and an integer register file. The float result goes to one and the zero-extended integer result goes to the other. An invalid-operation bit comes out with every result, and the surrounding core ORs it into its sticky exception flags.

Not-a-Number inputs get special treatment. In min/max, a signaling NaN in the second operand is checked first and returns the first operand. A signaling NaN in the first operand returns the second. A lone quiet NaN gives way to the other operand, and two quiet NaNs produce the canonical quiet NaN. Compares follow IEEE ordering, so the two zeros are equal. Min/max treats -0 as below +0.

A NaN has an all-ones exponent and a nonzero fraction. It is signaling when the top fraction bit is 0 and quiet when that bit is 1. Ordering is worked out on the sign-magnitude bit patterns, with no arithmetic.

Top module: `fp_cmp_unit`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it, `out_valid`, `fp_res`, `int_res` and `flag_invalid` are all zero, whatever `in_valid` and the operands are.
- R2: `out_valid` equals `in_valid` from one clock earlier. Results appear one cycle after the request. In a cycle where `out_valid` is low, `fp_res`, `int_res` and `flag_invalid` are zero.
- R3: With `grp_sel`=0 (min/max), `sub_op` bit 0 picks min (0) or max (1). `fp_res` carries the selected operand and `int_res` is zero. When both operands are numbers, the result is the numeric minimum or maximum, with -0 ordered below +0.
- R4: In min/max, if `op_b` is a signaling NaN, `fp_res` equals `op_a` and `flag_invalid` is 1. This rule wins over every other rule.
- R5: In min/max, if `op_a` is a signaling NaN and `op_b` is not, `fp_res` equals `op_b` and `flag_invalid` is 1.
- R6: In min/max with no signaling NaN, a single quiet NaN returns the other operand. Two quiet NaNs return 0x7FC00000. `flag_invalid` is 0 in both cases.
- R7: With `grp_sel`=1 (compare), `sub_op` selects the relation: 0 is less-or-equal, 1 is less-than, 2 is equal. The answer is in `int_res` bit 0, bits 63..1 are zero and `fp_res` is zero. Ordering is IEEE ordering, so -0 equals +0.
- R8: Less-or-equal and less-than return 0 and set `flag_invalid` whenever either operand is any NaN.
- R9: Equal returns 0 if either operand is a NaN. It sets `flag_invalid` only when an operand is a signaling NaN.
- R10: Compare with `sub_op`=3 returns `int_res`=0 and `flag_invalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled on this edge |
| grp_sel | input | 1 | 0 = min/max group, 1 = compare group |
| sub_op | input | 2 | Operation inside the group |
| op_a | input | 32 | First operand, binary32 bits |
| op_b | input | 32 | Second operand, binary32 bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| fp_res | output | 32 | Min/max result |
| int_res | output | 64 | Compare result, zero-extended |
| flag_invalid | output | 1 | Invalid-operation indication for the sticky flags |

## Verification
Two NaN rules of min/max can fire on the same request when both operands are signaling NaNs. They can also clash when a signaling NaN in `op_b` meets a quiet NaN in `op_a`. The sweep pairs every special value with every other, so both collisions occur. It expects `op_a` back with the invalid flag set, which shows that the second-operand rule has priority. The bench also judges the equal compare on a quiet NaN against one on a signaling NaN in the same sweep. This separates the silent invalid rule of equal from the noisy rule of the ordered compares.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic {
    GRP_MINMAX = 1'b0,
    GRP_CMP    = 1'b1
  } grp_e;

  typedef enum logic [1:0] {
    CMP_LE  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_EQ  = 2'd2,
    CMP_RSV = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
    logic is_inf;
  } opnd_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output opnd_class_t          cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_zero;

  always_comb begin
    exp_f    = val[W-2:MAN_W];
    man_f    = val[MAN_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    man_zero = ~|man_f;

    cls.sign    = val[W-1];
    cls.is_nan  = exp_ones & ~man_zero;
    cls.is_snan = exp_ones & ~man_zero & ~man_f[MAN_W-1];
    cls.is_qnan = exp_ones & man_f[MAN_W-1];
    cls.is_zero = exp_zero & man_zero;
    cls.is_inf  = exp_ones & man_zero;
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  opnd_class_t          ca,
  input  opnd_class_t          cb,
  output logic                 lt_total,
  output logic                 lt_ieee,
  output logic                 eq_ieee
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;
  logic         mag_lt;
  logic         mag_gt;
  logic         both_zero;

  always_comb begin
    mag_a     = a[W-2:0];
    mag_b     = b[W-2:0];
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    both_zero = ca.is_zero & cb.is_zero;

    unique case ({ca.sign, cb.sign})
      2'b00:   lt_total = mag_lt;
      2'b11:   lt_total = mag_gt;
      2'b10:   lt_total = 1'b1;
      default: lt_total = 1'b0;
    endcase

    lt_ieee = lt_total & ~both_zero;
    eq_ieee = (a == b) | both_zero;
  end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  grp_e                 grp,
  input  logic [1:0]           sub,
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  opnd_class_t          ca,
  input  opnd_class_t          cb,
  input  logic                 lt_total,
  input  logic                 lt_ieee,
  input  logic                 eq_ieee,
  output logic [EXP_W+MAN_W:0] fp_val,
  output logic                 cmp_bit,
  output logic                 invalid
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] CANON_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic any_nan;
  logic any_snan;
  logic pick_a;

  always_comb begin
    any_nan  = ca.is_nan | cb.is_nan;
    any_snan = ca.is_snan | cb.is_snan;
    fp_val   = '0;
    cmp_bit  = 1'b0;
    invalid  = 1'b0;
    pick_a   = 1'b0;

    if (grp == GRP_MINMAX) begin
      pick_a = sub[0] ? ~lt_total : lt_total;
      if (cb.is_snan) begin
        fp_val  = a;
        invalid = 1'b1;
      end else if (ca.is_snan) begin
        fp_val  = b;
        invalid = 1'b1;
      end else if (ca.is_nan && cb.is_nan) begin
        fp_val = CANON_QNAN;
      end else if (ca.is_nan) begin
        fp_val = b;
      end else if (cb.is_nan) begin
        fp_val = a;
      end else begin
        fp_val = pick_a ? a : b;
      end
    end else begin
      unique case (cmp_op_e'(sub))
        CMP_LE: begin
          invalid = any_nan;
          cmp_bit = ~any_nan & (lt_ieee | eq_ieee);
        end
        CMP_LT: begin
          invalid = any_nan;
          cmp_bit = ~any_nan & lt_ieee;
        end
        CMP_EQ: begin
          invalid = any_snan;
          cmp_bit = ~any_nan & eq_ieee;
        end
        default: begin
          invalid = 1'b0;
          cmp_bit = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XLEN  = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   grp_sel,
  input  logic [1:0]             sub_op,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   fp_res,
  output logic [XLEN-1:0]        int_res,
  output logic                   flag_invalid
);
  localparam int W    = 1 + EXP_W + MAN_W;
  localparam int N_OP = 2;

  logic [W-1:0] opnd [N_OP];
  opnd_class_t  cls  [N_OP];
  grp_e         grp;

  logic         lt_total;
  logic         lt_ieee;
  logic         eq_ieee;
  logic [W-1:0] fp_val;
  logic         cmp_bit;
  logic         invalid;

  always_comb begin
    opnd[0] = op_a;
    opnd[1] = op_b;
    grp     = grp_e'(grp_sel);
  end

  for (genvar gi = 0; gi < N_OP; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnd[gi]),
      .cls (cls[gi])
    );
  end

  fpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a        (op_a),
    .b        (op_b),
    .ca       (cls[0]),
    .cb       (cls[1]),
    .lt_total (lt_total),
    .lt_ieee  (lt_ieee),
    .eq_ieee  (eq_ieee)
  );

  fpcmp_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .grp      (grp),
    .sub      (sub_op),
    .a        (op_a),
    .b        (op_b),
    .ca       (cls[0]),
    .cb       (cls[1]),
    .lt_total (lt_total),
    .lt_ieee  (lt_ieee),
    .eq_ieee  (eq_ieee),
    .fp_val   (fp_val),
    .cmp_bit  (cmp_bit),
    .invalid  (invalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      fp_res       <= '0;
      int_res      <= '0;
      flag_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fp_res       <= (grp == GRP_MINMAX) ? fp_val : '0;
        int_res      <= (grp == GRP_CMP) ? {{(XLEN-1){1'b0}}, cmp_bit} : '0;
        flag_invalid <= invalid;
      end else begin
        fp_res       <= '0;
        int_res      <= '0;
        flag_invalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XLEN  = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 grp_sel,
  input logic [1:0]           sub_op,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] fp_res,
  input logic [XLEN-1:0]      int_res,
  input logic                 flag_invalid
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic a_nan;
  logic b_nan;
  logic b_snan;

  always_comb begin
    a_nan  = (&op_a[W-2:MAN_W]) & (|op_a[MAN_W-1:0]);
    b_nan  = (&op_b[W-2:MAN_W]) & (|op_b[MAN_W-1:0]);
    b_snan = b_nan & ~op_b[MAN_W-1];
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (fp_res == '0 && int_res == '0 && !flag_invalid));

  // R7
  int_width_chk: assert property (@(posedge clk) disable iff (rst)
    int_res[XLEN-1:1] == '0);

  // R3
  group_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int_res != '0) |-> fp_res == '0);

  // R4
  snan_b_first_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !grp_sel && b_snan) |=> (fp_res == $past(op_a) && flag_invalid));

  // R8
  ordered_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && grp_sel && !sub_op[1] && (a_nan || b_nan))
      |=> (int_res == '0 && flag_invalid));
endmodule

bind fp_cmp_unit fpcmp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .grp_sel      (grp_sel),
  .sub_op       (sub_op),
  .op_a         (op_a),
  .op_b         (op_b),
  .out_valid    (out_valid),
  .fp_res       (fp_res),
  .int_res      (int_res),
  .flag_invalid (flag_invalid)
);

// File: tb/fp_cmp_unit_bench.sv
`timescale 1ns/1ps
module fp_cmp_unit_bench;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        grp_sel = 1'b0;
  logic [1:0]  sub_op = 2'd0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] fp_res;
  logic [63:0] int_res;
  logic        flag_invalid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] vals [NV];
  int          rank [NV];

  fp_cmp_unit u_fp_cmp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .grp_sel(grp_sel),
    .sub_op(sub_op), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .fp_res(fp_res), .int_res(int_res), .flag_invalid(flag_invalid)
  );

  always #10 clk = ~clk;

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction

  task automatic check(string req, logic ov, logic [31:0] fp, logic [63:0] ir, logic fl);
    total++;
    if (out_valid !== ov || fp_res !== fp || int_res !== ir || flag_invalid !== fl) begin
      bad++;
      $display("FAIL %s: got v=%0b fp=%h int=%h inv=%0b, want v=%0b fp=%h int=%h inv=%0b",
               req, out_valid, fp_res, int_res, flag_invalid, ov, fp, ir, fl);
    end
  endtask

  task automatic run_one(int i, int j, bit g, logic [1:0] s);
    logic [31:0] a, b, efp;
    logic [63:0] eint;
    logic        efl;
    string       req;
    a = vals[i]; b = vals[j];
    efp = '0; eint = '0; efl = 1'b0; req = "R3";
    if (!g) begin
      if (is_snan(b)) begin efp = a; efl = 1; req = "R4"; end
      else if (is_snan(a)) begin efp = b; efl = 1; req = "R5"; end
      else if (is_nan(a) && is_nan(b)) begin efp = 32'h7FC00000; req = "R6"; end
      else if (is_nan(a)) begin efp = b; req = "R6"; end
      else if (is_nan(b)) begin efp = a; req = "R6"; end
      else if (rank[i] < rank[j]) efp = s[0] ? b : a;
      else if (rank[i] > rank[j]) efp = s[0] ? a : b;
      else if (a == b) efp = a;
      else efp = s[0] ? (a[31] ? b : a) : (a[31] ? a : b);
    end else begin
      if (s == 2'd3) req = "R10";
      else if (s == 2'd2) begin
        if (is_nan(a) || is_nan(b)) begin efl = is_snan(a) || is_snan(b); req = "R9"; end
        else begin eint[0] = rank[i] == rank[j]; req = "R7"; end
      end else begin
        if (is_nan(a) || is_nan(b)) begin efl = 1; req = "R8"; end
        else begin
          eint[0] = (s == 2'd0) ? (rank[i] <= rank[j]) : (rank[i] < rank[j]);
          req = "R7";
        end
      end
    end
    in_valid = 1; grp_sel = g; sub_op = s; op_a = a; op_b = b;
    @(negedge clk);
    check(req, 1'b1, efp, eint, efl);
  endtask

  initial begin
    vals[0]  = 32'hFF800000; rank[0]  = 0;
    vals[1]  = 32'hFF7FFFFF; rank[1]  = 1;
    vals[2]  = 32'hC0000000; rank[2]  = 2;
    vals[3]  = 32'hBF800000; rank[3]  = 3;
    vals[4]  = 32'h80000001; rank[4]  = 4;
    vals[5]  = 32'h80000000; rank[5]  = 5;
    vals[6]  = 32'h00000000; rank[6]  = 5;
    vals[7]  = 32'h00000001; rank[7]  = 6;
    vals[8]  = 32'h3F800000; rank[8]  = 7;
    vals[9]  = 32'h3FC00000; rank[9]  = 8;
    vals[10] = 32'h40000000; rank[10] = 9;
    vals[11] = 32'h7F7FFFFF; rank[11] = 10;
    vals[12] = 32'h7F800000; rank[12] = 11;
    vals[13] = 32'h7FC00000; rank[13] = -1;
    vals[14] = 32'hFFC00123; rank[14] = -1;
    vals[15] = 32'h7F800001; rank[15] = -1;
    vals[16] = 32'hFFA00000; rank[16] = -1;

    // R1: reset holds outputs at zero even with a live request
    in_valid = 1; op_a = 32'h3F800000; op_b = 32'h7F800001;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, '0, '0, 1'b0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    check("R1", 1'b0, '0, '0, 1'b0);

    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++) begin
        run_one(i, j, 1'b0, 2'd0);
        run_one(i, j, 1'b0, 2'd1);
        for (int s = 0; s < 4; s++) run_one(i, j, 1'b1, s[1:0]);
      end

    // R2: idle cycle with operands that would flag invalid
    in_valid = 0; grp_sel = 1; sub_op = 2'd0; op_a = 32'h7F800001; op_b = 32'h7FC00000;
    @(negedge clk);
    check("R2", 1'b0, '0, '0, 1'b0);
    run_one(3, 8, 1'b1, 2'd1);
    in_valid = 0;
    @(negedge clk);
    check("R2", 1'b0, '0, '0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule